// File: doc/BRIEF.md
# Single-Cycle Integer Core (add/sub/addi/lw/sw/beq)

This block is a 32-bit processor core that completes every instruction in one clock period. In a single period it reads the instruction word, decodes it, reads two registers, runs the ALU, touches data memory if the instruction needs it, and writes the result back. At the closing clock edge it loads the next program counter. The core executes six instructions: register add and subtract, add-immediate, load word, store word, and branch-if-equal.

No resource is shared within an instruction, so the block has separate storage for instructions and data. Two dedicated adders, one for the sequential address and one for the branch target, sit alongside the ALU. Decoding is split in two. A main decoder works from the opcode. A small second decoder turns the main decoder's ALU request and the function field into an add or a subtract.

The program is loaded through a write port while reset is held. A debug port shows the program counter and lets one register be read at any time.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register and data memory word becomes 0 at that edge.
- R2: After any instruction that is not a taken branch, the PC becomes PC+4 at the next edge.
- R3: Opcode 0x00 with function field 0x20 writes rs+rt to rd. With function field 0x22 it writes rs-rt to rd. The fields are rs = bits [25:21], rt = bits [20:16], rd = bits [15:11], and function = bits [5:0].
- R4: Opcode 0x08 writes rs plus the sign-extended bits [15:0] to rt.
- R5: Opcode 0x23 loads rt from the data word indexed by bits [7:2] of rs+sext(imm). Higher address bits are ignored.
- R6: Opcode 0x2B stores rt to the data word indexed by bits [7:2] of rs+sext(imm). It writes no register.
- R7: Opcode 0x04 sets the PC to PC+4+(sext(imm)<<2) when rs equals rt, and to PC+4 otherwise. It writes no register and no memory.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: Any other opcode writes no register and no memory. The PC advances by 4.
- R10: A high `imem_we` at an edge stores `imem_wdata` into instruction word `imem_waddr`. The word at byte address PC is the instruction executed. `dbg_rdata` shows register `dbg_raddr` combinationally, and `dbg_pc` shows the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | 6 | Instruction word index to write |
| imem_wdata | input | 32 | Instruction word to store |
| dbg_raddr | input | 5 | Register index for the debug read |
| dbg_pc | output | 32 | Current program counter |
| dbg_rdata | output | 32 | Contents of register `dbg_raddr` |

## Verification
A fault in the next-PC logic appears on `dbg_pc` at the very next edge, because the PC is compared after every cycle against an independent instruction-level model. A wrong register write does not show on the PC right away. It surfaces as a wrong branch decision once a later beq compares that register, or in the register sweep at the end of each program. A wrong data memory index or store enable shows up only when a later load brings the word back into a register. For this reason the random programs mix stores and loads, use a small register pool, and include aliased addresses.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int IMMW = 16;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluop_e;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } alu_fn_e;

  typedef struct packed {
    logic   reg_dst;
    logic   branch;
    logic   mem_read;
    logic   mem_to_reg;
    aluop_e alu_op;
    logic   mem_write;
    logic   alu_src;
    logic   reg_write;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] imm);
    return {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] seq_pc(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc4,
                                                input logic [XLEN-1:0] off);
    return pc4 + {off[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_fn_e fn,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return (fn == ALU_SUB) ? (a - b) : (a + b);
  endfunction
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl,
  output logic       op_known
);
  always_comb begin
    ctl      = '0;
    op_known = 1'b1;
    unique case (opcode)
      OPC_RTYPE: begin
        ctl.reg_dst   = 1'b1;
        ctl.alu_op    = AOP_FUNCT;
        ctl.reg_write = 1'b1;
      end
      OPC_ADDI: begin
        ctl.alu_src   = 1'b1;
        ctl.reg_write = 1'b1;
      end
      OPC_LW: begin
        ctl.alu_src    = 1'b1;
        ctl.mem_read   = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_write  = 1'b1;
      end
      OPC_SW: begin
        ctl.alu_src   = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = AOP_SUB;
      end
      default: op_known = 1'b0;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  aluop_e     alu_op,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);
  always_comb begin
    unique case (alu_op)
      AOP_SUB:   fn = ALU_SUB;
      AOP_FUNCT: fn = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
      default:   fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NRD  = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NRD-1:0][$clog2(NREG)-1:0] ra,
  output logic [NRD-1:0][DW-1:0]           rd,
  input  logic                            we,
  input  logic [$clog2(NREG)-1:0]          wa,
  input  logic [DW-1:0]                   wd
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != AW'(0))) begin
      regs[wa] <= wd;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd[p] = (ra[p] == AW'(0)) ? '0 : regs[ra[p]];
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_fn_e         fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_eval(fn, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          imem_we,
  input  logic [$clog2(IMEM_WORDS)-1:0] imem_waddr,
  input  logic [31:0]                   imem_wdata,
  input  logic [$clog2(NREG)-1:0]       dbg_raddr,
  output logic [31:0]                   dbg_pc,
  output logic [31:0]                   dbg_rdata
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc4, br_target, pc_next;
  logic [XLEN-1:0] instr;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end
  assign instr = imem[pc_q[IAW+1:2]];

  logic [5:0]      f_op, f_fn;
  logic [RAW-1:0]  f_rs, f_rt, f_rd;
  logic [15:0]     f_imm;
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];
  assign f_fn  = instr[5:0];

  ctrl_t   ctl;
  logic    op_known;
  alu_fn_e alu_fn;

  sc_main_dec u_mdec (.opcode(f_op), .ctl(ctl), .op_known(op_known));
  sc_alu_dec  u_adec (.alu_op(ctl.alu_op), .funct(f_fn), .fn(alu_fn));

  logic [2:0][RAW-1:0]  rf_ra;
  logic [2:0][XLEN-1:0] rf_rd;
  logic [RAW-1:0]       wb_addr;
  logic [XLEN-1:0]      wb_data;

  assign rf_ra = {dbg_raddr, f_rt, f_rs};

  sc_regfile #(.NREG(NREG), .DW(XLEN), .NRD(3)) u_rf (
    .clk(clk), .rst(rst), .ra(rf_ra), .rd(rf_rd),
    .we(ctl.reg_write), .wa(wb_addr), .wd(wb_data)
  );

  logic [XLEN-1:0] imm_x, opnd_b, alu_y, mem_rdata;
  logic            alu_zero, br_taken;

  assign imm_x  = sext_imm(f_imm);
  assign opnd_b = ctl.alu_src ? imm_x : rf_rd[1];

  sc_alu u_alu (.fn(alu_fn), .a(rf_rd[0]), .b(opnd_b), .y(alu_y), .zero(alu_zero));

  logic [DAW-1:0] dm_idx;
  assign dm_idx    = alu_y[DAW+1:2];
  assign mem_rdata = ctl.mem_read ? dmem[dm_idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (ctl.mem_write) begin
      dmem[dm_idx] <= rf_rd[1];
    end
  end

  assign wb_addr = ctl.reg_dst ? f_rd : f_rt;
  assign wb_data = ctl.mem_to_reg ? mem_rdata : alu_y;

  assign pc4       = seq_pc(pc_q);
  assign br_target = jump_dest(pc4, imm_x);
  assign br_taken  = ctl.branch && alu_zero;
  assign pc_next   = br_taken ? br_target : pc4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc    = pc_q;
  assign dbg_rdata = rf_rd[2];

  AST_PC_RESET: assert property (@(posedge clk) rst |=> (pc_q == '0)); // R1
  AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> (pc_q == $past(pc_q) + 32'd4)); // R2
  AST_BR_DEST: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc_q == $past(br_target))); // R7
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_write |-> !ctl.reg_write); // R6
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !op_known |-> (!ctl.reg_write && !ctl.mem_write && !ctl.branch)); // R9
endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic [4:0]  dbg_raddr = '0;
  logic [31:0] dbg_pc, dbg_rdata;

  always #4 clk = ~clk;

  sc_core dut (.clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .dbg_raddr(dbg_raddr), .dbg_pc(dbg_pc), .dbg_rdata(dbg_rdata));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] prog [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;

  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] sx(logic [15:0] v);
    logic [31:0] r;
    r = 32'(signed'(v));
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_wr(logic [4:0] r, logic [31:0] v);
    if (r != 5'd0) m_reg[r] = v;
  endtask

  task automatic m_step();
    logic [31:0] ins, a, b, ea, nxt;
    ins = prog[m_pc[7:2]];
    a   = m_reg[ins[25:21]];
    b   = m_reg[ins[20:16]];
    ea  = a + sx(ins[15:0]);
    nxt = m_pc + 32'd4;
    case (ins[31:26])
      6'h00: m_wr(ins[15:11], (ins[5:0] == 6'h22) ? a - b : a + b);
      6'h08: m_wr(ins[20:16], ea);
      6'h23: m_wr(ins[20:16], m_mem[ea[7:2]]);
      6'h2B: m_mem[ea[7:2]] = b;
      6'h04: if (a == b) nxt = nxt + (sx(ins[15:0]) << 2);
      default: ;
    endcase
    m_pc = nxt;
  endtask

  task automatic load_and_reset();
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_pc = '0;
    chk("R1 pc after reset", dbg_pc, 32'd0);
    for (int i = 0; i < 32; i++) begin
      dbg_raddr = 5'(i); #0.5;
      chk("R1 register after reset", dbg_rdata, 32'd0);
    end
    rst = 1'b0;
  endtask

  task automatic run_prog(int cycles);
    for (int c = 0; c < cycles; c++) begin
      m_step();
      @(negedge clk);
      chk("R2/R7/R10 pc trace", dbg_pc, m_pc);
    end
    for (int i = 0; i < 32; i++) begin
      dbg_raddr = 5'(i); #0.5;
      chk("R3/R4/R5/R6/R8/R9 register file", dbg_rdata, m_reg[i]);
    end
  endtask

  function automatic logic [31:0] rand_instr(int idx);
    int k, rs, rt, rd;
    k  = int'($urandom % 8);
    rs = int'($urandom % 8);
    rt = int'($urandom % 8);
    rd = int'($urandom % 8);
    case (k)
      0: return enc_r(rs, rt, rd, 6'h20);
      1: return enc_r(rs, rt, rd, 6'h22);
      2, 3: return enc_i(6'h08, rs, rt, 16'($urandom));
      4: return enc_i(6'h23, rs, rt, 16'($urandom % 512) & 16'hFFFC);
      5: return enc_i(6'h2B, rs, rt, 16'($urandom % 512) & 16'hFFFC);
      6: return (idx < 38) ? enc_i(6'h04, rs, rt, 16'(1 + $urandom % 2)) : enc_r(rs, rt, rd, 6'h20);
      default: return {6'h3F, 26'($urandom)};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 64; i++) prog[i] = HALT;
    prog[0]  = enc_i(6'h08, 0, 1, 16'hFFFD);
    prog[1]  = enc_i(6'h08, 0, 0, 16'd7);
    prog[2]  = enc_r(1, 1, 2, 6'h20);
    prog[3]  = enc_i(6'h2B, 0, 2, 16'd8);
    prog[4]  = enc_i(6'h23, 0, 3, 16'd264);
    prog[5]  = enc_i(6'h04, 3, 2, 16'd1);
    prog[6]  = enc_i(6'h08, 0, 4, 16'd99);
    prog[7]  = enc_r(0, 1, 5, 6'h22);
    prog[8]  = {6'h3F, 5'd0, 5'd6, 16'd5};
    prog[9]  = enc_i(6'h04, 5, 1, 16'd5);
    prog[10] = enc_i(6'h04, 0, 0, 16'hFFFE);
    load_and_reset();
    m_step(); @(negedge clk); chk("R2 pc after addi", dbg_pc, 32'd4);
    run_prog(20);
    dbg_raddr = 5'd1; #0.5; chk("R4 negative immediate", dbg_rdata, 32'hFFFF_FFFD);
    dbg_raddr = 5'd0; #0.5; chk("R8 write to register 0 dropped", dbg_rdata, 32'd0);
    dbg_raddr = 5'd2; #0.5; chk("R3 add result", dbg_rdata, 32'hFFFF_FFFA);
    dbg_raddr = 5'd3; #0.5; chk("R5 aliased load", dbg_rdata, 32'hFFFF_FFFA);
    dbg_raddr = 5'd4; #0.5; chk("R7 taken branch skipped write", dbg_rdata, 32'd0);
    dbg_raddr = 5'd5; #0.5; chk("R3 sub result", dbg_rdata, 32'd3);
    dbg_raddr = 5'd6; #0.5; chk("R9 unknown opcode no write", dbg_rdata, 32'd0);
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 64; i++) prog[i] = (i < 40) ? rand_instr(i) : HALT;
      load_and_reset();
      run_prog(60);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule